// File: doc/BRIEF.md
# Pixel Hit-Cluster Zero-Suppression Engine

The engine turns binary hit maps from a rolling-shutter pixel matrix into a sparse stream. On each read step it takes one pair of rows, with one discriminator bit per column. Two consecutive steps form a four-row band. Inside a band the columns are searched from lowest to highest. Every group of hits is reported as a window five columns wide and four rows tall. A window is stored as one 32-bit word that holds the band index, the anchor column and a 20-bit hit pattern. Hits that an earlier window already covers are not reported again.

A frame is a fixed number of row-pair steps (`NPAIR`). Its words go into one of four memory banks, framed by a header word and a trailer word. The banks are filled in rotation. When a frame ends it is either kept for output or dropped: continuous mode keeps every frame, and triggered mode keeps only the frames during which a trigger was seen. A serializer drains the kept banks in the order they were filled, on one or two bit lanes. Row-pair steps must be spaced far enough apart for a band's search to finish, which takes at most one cycle per window plus one.

Top module: `zs_engine`

## Requirements
- R1: After reset, `ser_valid` is 0, both `ser_data` lanes are 0 and `frames_lost` is 0.
- R2: The steps of a frame are numbered 0 to NPAIR-1. Steps 2k and 2k+1 form band k. In the band, rows 0 and 1 come from `pair_row0` and `pair_row1` of step 2k, and rows 2 and 3 come from step 2k+1. Hit-pattern bit r*5+j holds row r, column anchor+j. Columns past the last one read as 0.
- R3: Each window is anchored at the lowest hit column that is not below the end of the previous window in the same band, and it spans that column and the next four. A band with no hits produces no window.
- R4: A window word holds bits[31:30]=01, bits[29:26]=band index, bits[25:20]=anchor column and bits[19:0]=hit pattern.
- R5: Each stored frame begins with a header word, bits[31:30]=10, bits[15:0]=frame number, all other bits 0. Frame numbers start at 0 after reset and advance by one for every frame, whether it is kept or not.
- R6: At most MAX_WIN windows are stored per frame and later windows are dropped. The trailer word holds bits[31:30]=11, bit 16 set when windows were dropped, and bits[15:0] set to the number of stored windows.
- R7: Frames go to banks 0,1,2,3,0,… in turn. If the next bank has not been fully sent when a frame starts, that frame is discarded and `frames_lost` increments by one.
- R8: With `trig_mode`=0 every frame is output. With `trig_mode`=1 a frame is output only if `trigger` was high in some cycle from its first step to its trailer. Otherwise its bank is reused.
- R9: With `two_lane`=0, each word is sent MSB first on lane 0 over 32 cycles and lane 1 stays 0. With `two_lane`=1, bits[31:16] go on lane 0 and bits[15:0] on lane 1, each MSB first, over 16 cycles. The lane mode is taken when a bank starts to drain. `ser_valid` is high on every bit cycle.
- R10: Banks are sent whole and in the order they were filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pair_valid | input | 1 | One-cycle strobe for a row-pair step |
| pair_row0 | input | NCOL | First row of the pair, bit c = column c |
| pair_row1 | input | NCOL | Second row of the pair |
| trig_mode | input | 1 | 0 continuous, 1 triggered |
| trigger | input | 1 | Selects the current frame in triggered mode |
| two_lane | input | 1 | 1 selects two serial lanes |
| ser_data | output | 2 | Serial lanes, bit 0 = lane 0 |
| ser_valid | output | 1 | Serial bit cycle |
| frames_lost | output | 16 | Count of frames discarded for lack of a free bank |

## Verification
A table of one-band frames is used: an empty band, single hits in the lowest and the highest column, and two hits in different rows joined into one window. Together these separate a wrong anchor, a wrong row order and any wrap past the last column. Two hits five columns apart must give two windows rather than one, and a fully hit row must overflow the window limit and set the trailer flag. The same frame is then sent in two-lane mode to compare lane splitting. Triggered frames with and without a trigger tell selection apart from plain discard. A burst of frames faster than the drain rate shows both the loss count and the order of output.

// File: rtl/zs_pkg.sv
package zs_pkg;
    localparam int WORD_W   = 32;
    localparam int WIN_ROWS = 4;
    localparam int WIN_COLS = 5;
    localparam int PAT_W    = WIN_ROWS * WIN_COLS;

    typedef enum logic [1:0] {
        TAG_NONE = 2'b00,
        TAG_WIN  = 2'b01,
        TAG_HDR  = 2'b10,
        TAG_TRL  = 2'b11
    } tag_e;

    typedef struct packed {
        tag_e             tag;
        logic [3:0]       band;
        logic [5:0]       col;
        logic [PAT_W-1:0] pat;
    } win_word_t;
endpackage

// File: rtl/zs_win_finder.sv
// Window finder: pairs row steps into 4-row bands and, one window per cycle,
// reports 4x5 windows anchored at the lowest uncovered hit column.
// Assumes: NPAIR even, 5 <= NCOL <= 64, and steps spaced wider than a band scan.
module zs_win_finder
    import zs_pkg::*;
#(
    parameter int NCOL  = 16,
    parameter int NPAIR = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pair_valid,
    input  logic [NCOL-1:0] row_a,
    input  logic [NCOL-1:0] row_b,
    output logic            frame_start,
    output logic            win_valid,
    output win_word_t       win_word,
    output logic            frame_end
);
    localparam int SW = (NPAIR > 2) ? $clog2(NPAIR) : 1;
    localparam int NW = $clog2(NCOL + WIN_COLS);

    logic [SW-1:0]   stp;
    logic [NCOL-1:0] prev_a, prev_b;
    logic [NCOL-1:0] band_q [WIN_ROWS];
    logic            scanning, last_q, hit_found;
    logic [3:0]      band_idx;
    logic [NW-1:0]   nxt, anchor;
    logic [NCOL-1:0] col_or;
    logic [PAT_W-1:0] pat;

    // Column occupancy of the whole band
    always_comb begin
        col_or = '0;
        for (int r = 0; r < WIN_ROWS; r++) col_or |= band_q[r];
    end

    // Lowest hit column at or above the uncovered boundary
    always_comb begin
        hit_found = 1'b0;
        anchor    = '0;
        for (int c = 0; c < NCOL; c++) begin
            if (!hit_found && col_or[c] && (NW'(c) >= nxt)) begin
                hit_found = 1'b1;
                anchor    = NW'(c);
            end
        end
    end

    // One 5-bit slice of the pattern per band row
    for (genvar r = 0; r < WIN_ROWS; r++) begin : g_row
        logic [NCOL-1:0] shf;
        assign shf = band_q[r] >> anchor;
        assign pat[r*WIN_COLS +: WIN_COLS] = shf[WIN_COLS-1:0];
    end

    assign frame_start = pair_valid && (stp == '0);
    assign win_valid   = scanning && hit_found;
    assign frame_end   = scanning && !hit_found && last_q;
    assign win_word    = '{tag: TAG_WIN, band: band_idx, col: 6'(anchor), pat: pat};

    // Step counting, band capture and scan progress
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stp      <= '0;
            scanning <= 1'b0;
            last_q   <= 1'b0;
            nxt      <= '0;
            band_idx <= '0;
        end else if (pair_valid) begin
            prev_a <= row_a;
            prev_b <= row_b;
            stp    <= (stp == SW'(NPAIR-1)) ? '0 : stp + 1'b1;
            if (stp[0]) begin
                band_q[0] <= prev_a;
                band_q[1] <= prev_b;
                band_q[2] <= row_a;
                band_q[3] <= row_b;
                scanning  <= 1'b1;
                nxt       <= '0;
                band_idx  <= 4'(stp >> 1);
                last_q    <= (stp == SW'(NPAIR-1));
            end
        end else if (scanning) begin
            if (hit_found) nxt <= anchor + NW'(WIN_COLS);
            else           scanning <= 1'b0;
        end
    end
endmodule

// File: rtl/zs_bank_ctrl.sv
// Bank store: writes header, windows and trailer of each frame into a rotating
// bank, applies the window limit, keeps or drops the frame by mode and trigger,
// and counts frames that find their bank still occupied.
// Assumes: NBANK a power of two; win_valid and frame_end never coincide.
module zs_bank_ctrl
    import zs_pkg::*;
#(
    parameter int NBANK   = 4,
    parameter int MAX_WIN = 6,
    localparam int DEPTH  = MAX_WIN + 2,
    localparam int AW     = $clog2(DEPTH),
    localparam int BW     = $clog2(NBANK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              win_valid,
    input  logic [WORD_W-1:0] win_word,
    input  logic              frame_end,
    input  logic              trig_mode,
    input  logic              trigger,
    input  logic [BW-1:0]     rd_bank,
    input  logic [AW-1:0]     rd_addr,
    input  logic              rel,
    output logic [WORD_W-1:0] rd_data,
    output logic [AW:0]       rd_len,
    output logic [NBANK-1:0]  bank_full,
    output logic [15:0]       frames_lost
);
    logic [WORD_W-1:0] mem [NBANK][DEPTH];
    logic [AW:0]       len_q [NBANK];
    logic [BW-1:0]     wr_ptr;
    logic [AW-1:0]     wr_addr, nwin, wa;
    logic              open_q, ovf_q, trig_q, we, keep;
    logic [15:0]       fcnt;
    logic [WORD_W-1:0] wd;

    assign rd_data = mem[rd_bank][rd_addr];
    assign rd_len  = len_q[rd_bank];
    assign keep    = !trig_mode || trig_q || trigger;

    // Select which word, if any, is written this cycle
    always_comb begin
        we = 1'b0;
        wa = wr_addr;
        wd = '0;
        if (frame_start && !bank_full[wr_ptr]) begin
            we = 1'b1;
            wa = '0;
            wd = {TAG_HDR, 14'b0, fcnt};
        end else if (open_q && win_valid && (nwin < AW'(MAX_WIN))) begin
            we = 1'b1;
            wd = win_word;
        end else if (open_q && frame_end) begin
            we = 1'b1;
            wd = {TAG_TRL, 13'b0, ovf_q, 16'(nwin)};
        end
    end

    // Bank storage write port
    always_ff @(posedge clk) begin
        if (we) mem[wr_ptr][wa] <= wd;
    end

    // Frame bookkeeping, bank ownership and loss count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr      <= '0;
            wr_addr     <= '0;
            nwin        <= '0;
            open_q      <= 1'b0;
            ovf_q       <= 1'b0;
            trig_q      <= 1'b0;
            fcnt        <= '0;
            frames_lost <= '0;
            bank_full   <= '0;
            for (int b = 0; b < NBANK; b++) len_q[b] <= '0;
        end else begin
            if (rel) bank_full[rd_bank] <= 1'b0;
            if (frame_start) begin
                fcnt <= fcnt + 16'd1;
                if (!bank_full[wr_ptr]) begin
                    open_q  <= 1'b1;
                    wr_addr <= AW'(1);
                    nwin    <= '0;
                    ovf_q   <= 1'b0;
                    trig_q  <= trigger;
                end else begin
                    open_q      <= 1'b0;
                    frames_lost <= frames_lost + 16'd1;
                end
            end else if (open_q) begin
                trig_q <= trig_q || trigger;
                if (win_valid) begin
                    if (nwin < AW'(MAX_WIN)) begin
                        wr_addr <= wr_addr + 1'b1;
                        nwin    <= nwin + 1'b1;
                    end else begin
                        ovf_q <= 1'b1;
                    end
                end
                if (frame_end) begin
                    open_q <= 1'b0;
                    if (keep) begin
                        bank_full[wr_ptr] <= 1'b1;
                        len_q[wr_ptr]     <= {1'b0, wr_addr} + (AW+1)'(1);
                        wr_ptr            <= wr_ptr + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/zs_serializer.sv
// Serializer: drains full banks in order, one 32-bit word after another, on
// one lane (32 cycles/word) or two lanes (16 cycles/word), MSB first.
// Assumes: the bank store reads combinationally.
module zs_serializer
    import zs_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int AW    = 3,
    localparam int BW   = $clog2(NBANK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              two_lane,
    input  logic [NBANK-1:0]  bank_full,
    input  logic [AW:0]       rd_len,
    input  logic [WORD_W-1:0] rd_data,
    output logic [BW-1:0]     rd_bank,
    output logic [AW-1:0]     rd_addr,
    output logic              rel,
    output logic [1:0]        ser_data,
    output logic              ser_valid,
    output logic              lanes2
);
    logic              active, last_beat;
    logic [BW-1:0]     bank_q;
    logic [AW:0]       addr_q;
    logic [WORD_W-1:0] sh;
    logic [4:0]        bcnt;

    assign rd_bank     = bank_q;
    assign rd_addr     = active ? addr_q[AW-1:0] : '0;
    assign last_beat   = lanes2 ? (bcnt == 5'd15) : (bcnt == 5'd31);
    assign rel         = active && last_beat && (addr_q == rd_len);
    assign ser_valid   = active;
    assign ser_data[0] = active && sh[31];
    assign ser_data[1] = active && lanes2 && sh[15];

    // Word loading, bit shifting and bank hand-back
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            bank_q <= '0;
            addr_q <= '0;
            sh     <= '0;
            bcnt   <= '0;
            lanes2 <= 1'b0;
        end else if (!active) begin
            if (bank_full[bank_q]) begin
                active <= 1'b1;
                sh     <= rd_data;
                addr_q <= (AW+1)'(1);
                bcnt   <= '0;
                lanes2 <= two_lane;
            end
        end else if (last_beat) begin
            if (addr_q == rd_len) begin
                active <= 1'b0;
                bank_q <= bank_q + 1'b1;
            end else begin
                sh     <= rd_data;
                addr_q <= addr_q + 1'b1;
                bcnt   <= '0;
            end
        end else begin
            bcnt <= bcnt + 5'd1;
            sh   <= lanes2 ? {sh[30:16], 1'b0, sh[14:0], 1'b0} : {sh[30:0], 1'b0};
        end
    end
endmodule

// File: rtl/zs_engine.sv
// Top of the zero-suppression engine: window finder -> bank store -> serializer.
// Assumes: row-pair steps arrive at the rolling-shutter pace, far apart in clocks.
module zs_engine
    import zs_pkg::*;
#(
    parameter int NCOL    = 16,
    parameter int NPAIR   = 4,
    parameter int NBANK   = 4,
    parameter int MAX_WIN = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pair_valid,
    input  logic [NCOL-1:0] pair_row0,
    input  logic [NCOL-1:0] pair_row1,
    input  logic            trig_mode,
    input  logic            trigger,
    input  logic            two_lane,
    output logic [1:0]      ser_data,
    output logic            ser_valid,
    output logic [15:0]     frames_lost
);
    localparam int DEPTH = MAX_WIN + 2;
    localparam int AW    = $clog2(DEPTH);
    localparam int BW    = $clog2(NBANK);

    logic              frame_start, win_valid, frame_end, rel, lanes2;
    win_word_t         win_word;
    logic [WORD_W-1:0] rd_data;
    logic [AW:0]       rd_len;
    logic [NBANK-1:0]  bank_full;
    logic [BW-1:0]     rd_bank;
    logic [AW-1:0]     rd_addr;

    zs_win_finder #(.NCOL(NCOL), .NPAIR(NPAIR)) u_find (
        .clk(clk), .rst_n(rst_n), .pair_valid(pair_valid),
        .row_a(pair_row0), .row_b(pair_row1),
        .frame_start(frame_start), .win_valid(win_valid),
        .win_word(win_word), .frame_end(frame_end)
    );

    zs_bank_ctrl #(.NBANK(NBANK), .MAX_WIN(MAX_WIN)) u_bank (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .win_valid(win_valid), .win_word(win_word), .frame_end(frame_end),
        .trig_mode(trig_mode), .trigger(trigger),
        .rd_bank(rd_bank), .rd_addr(rd_addr), .rel(rel),
        .rd_data(rd_data), .rd_len(rd_len), .bank_full(bank_full),
        .frames_lost(frames_lost)
    );

    zs_serializer #(.NBANK(NBANK), .AW(AW)) u_ser (
        .clk(clk), .rst_n(rst_n), .two_lane(two_lane),
        .bank_full(bank_full), .rd_len(rd_len), .rd_data(rd_data),
        .rd_bank(rd_bank), .rd_addr(rd_addr), .rel(rel),
        .ser_data(ser_data), .ser_valid(ser_valid), .lanes2(lanes2)
    );
endmodule

// File: rtl/zs_engine_chk.sv
// Checker for zs_engine: relations between finder, bank store and serializer.
module zs_engine_chk #(
    parameter int NCOL  = 16,
    parameter int NBANK = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             win_valid,
    input logic [31:0]      win_word,
    input logic [NBANK-1:0] bank_full,
    input logic             ser_valid,
    input logic [1:0]       ser_data,
    input logic             lanes2,
    input logic [15:0]      frames_lost
);
    // R3
    anchor_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (win_word[0] | win_word[5] | win_word[10] | win_word[15]));
    // R3
    anchor_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (int'(win_word[25:20]) < NCOL));
    // R7
    lost_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (frames_lost == $past(frames_lost)) || (frames_lost == $past(frames_lost) + 16'd1));
    // R10
    drain_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_valid |-> (bank_full != '0));
    // R9
    lane1_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lanes2 |-> !ser_data[1]);
    // R9
    lane_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_valid && $past(ser_valid)) |-> $stable(lanes2));
endmodule

bind zs_engine zs_engine_chk #(.NCOL(NCOL), .NBANK(NBANK)) chk_i (
    .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_word(win_word),
    .bank_full(bank_full), .ser_valid(ser_valid), .ser_data(ser_data),
    .lanes2(lanes2), .frames_lost(frames_lost)
);

// File: tb/zs_engine_tb_top.sv
module zs_engine_tb_top;
    localparam int CLK_T = 10;
    localparam int NC    = 16;
    localparam int MW    = 3;
    localparam int NV    = 6;

    // hit map {row3,row2,row1,row0}, windows found, first anchor, first pattern
    localparam logic [63:0] HITS [NV] = '{64'h0, 64'h1, 64'h8000_0000_0000_0000,
                                          64'h0000_0040_0004_0000, 64'h0108,
                                          64'h0000_FFFF_0000_0000};
    localparam int          NWIN [NV] = '{0, 1, 1, 1, 2, 4};
    localparam int          C0   [NV] = '{0, 0, 15, 2, 3, 0};
    localparam logic [19:0] P0   [NV] = '{20'h0, 20'h00001, 20'h08000, 20'h04020,
                                          20'h00001, 20'h07C00};

    logic clk = 1'b0, rst_n = 1'b0, pair_valid = 1'b0;
    logic [NC-1:0] pair_row0 = '0, pair_row1 = '0;
    logic trig_mode = 1'b0, trigger = 1'b0, two_lane = 1'b0;
    logic [1:0] ser_data;
    logic ser_valid;
    logic [15:0] frames_lost;

    int total = 0, bad = 0, fnum = 0, beat = 0, lane1_err = 0;
    logic tb_two = 1'b0;
    logic [31:0] acc;
    logic [15:0] hi, lo;
    logic [31:0] rxq [$];

    always #(CLK_T/2) clk = ~clk;

    zs_engine #(.NCOL(NC), .NPAIR(2), .NBANK(4), .MAX_WIN(MW)) dut_i (
        .clk(clk), .rst_n(rst_n), .pair_valid(pair_valid),
        .pair_row0(pair_row0), .pair_row1(pair_row1), .trig_mode(trig_mode),
        .trigger(trigger), .two_lane(two_lane), .ser_data(ser_data),
        .ser_valid(ser_valid), .frames_lost(frames_lost)
    );

    // Serial receiver: rebuilds 32-bit words from the lanes
    always @(negedge clk) begin
        if (ser_valid) begin
            if (tb_two) begin
                hi = {hi[14:0], ser_data[0]};
                lo = {lo[14:0], ser_data[1]};
                beat++;
                if (beat == 16) begin rxq.push_back({hi, lo}); beat = 0; end
            end else begin
                acc = {acc[30:0], ser_data[0]};
                if (ser_data[1]) lane1_err++;
                beat++;
                if (beat == 32) begin rxq.push_back(acc); beat = 0; end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic [63:0] h, input logic trg);
        @(negedge clk);
        pair_valid = 1'b1; pair_row0 = h[15:0]; pair_row1 = h[31:16];
        @(negedge clk);
        pair_valid = 1'b0;
        repeat (11) @(negedge clk);
        pair_valid = 1'b1; pair_row0 = h[47:32]; pair_row1 = h[63:48]; trigger = trg;
        @(negedge clk);
        pair_valid = 1'b0; trigger = 1'b0;
        repeat (11) @(negedge clk);
        fnum++;
    endtask

    function automatic logic [31:0] hdr(input int n);
        return {2'b10, 14'b0, 16'(n)};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ser_valid", 32'(ser_valid), 32'd0);
        chk("R1 ser_data", 32'(ser_data), 32'd0);
        chk("R1 frames_lost", 32'(frames_lost), 32'd0);

        // Table walk: one band per frame, single lane, continuous mode
        for (int i = 0; i < NV; i++) begin
            int fc, nst;
            rxq.delete();
            fc  = fnum;
            nst = (NWIN[i] > MW) ? MW : NWIN[i];
            send_frame(HITS[i], 1'b0);
            repeat (200) @(negedge clk);
            chk("R3/R6 word count", 32'(rxq.size()), 32'(nst + 2));
            chk("R5 header", rxq[0], hdr(fc));
            // R6 trailer: overflow flag and stored count
            chk("R6 trailer", rxq[rxq.size()-1],
                {2'b11, 13'b0, (NWIN[i] > MW), 16'(nst)});
            if (NWIN[i] > 0)
                // R2 R3 R4 first window: band 0, anchor, row-major pattern
                chk("R2/R3/R4 window", rxq[1], {2'b01, 4'd0, 6'(C0[i]), P0[i]});
        end
        chk("R9 lane1 idle in one-lane mode", 32'(lane1_err), 32'd0);

        // R9 two-lane split; R3 two windows five columns apart
        rxq.delete();
        two_lane = 1'b1; tb_two = 1'b1;
        send_frame(64'h0108, 1'b0);
        repeat (120) @(negedge clk);
        chk("R9 two-lane count", 32'(rxq.size()), 32'd4);
        chk("R9 two-lane w1", rxq[1], {2'b01, 4'd0, 6'd3, 20'h00001});
        chk("R3 second anchor", rxq[2], {2'b01, 4'd0, 6'd8, 20'h00001});
        chk("R9 two-lane trailer", rxq[3], {2'b11, 13'b0, 1'b0, 16'd2});
        two_lane = 1'b0; tb_two = 1'b0;

        // R8 triggered mode
        trig_mode = 1'b1;
        rxq.delete();
        send_frame(64'h1, 1'b0);
        repeat (150) @(negedge clk);
        chk("R8 untriggered frame dropped", 32'(rxq.size()), 32'd0);
        begin
            int fc;
            fc = fnum;
            send_frame(64'h1, 1'b1);
            repeat (150) @(negedge clk);
            chk("R8 triggered frame kept", 32'(rxq.size()), 32'd3);
            chk("R5 counter counts dropped frames", rxq[0], hdr(fc));
        end
        trig_mode = 1'b0;

        // R7 bank exhaustion; R10 drain order
        rxq.delete();
        begin
            int fc0;
            fc0 = fnum;
            for (int f = 0; f < 6; f++) send_frame(HITS[5], 1'b0);
            repeat (900) @(negedge clk);
            chk("R7 frames_lost", 32'(frames_lost), 32'd2);
            chk("R7 words of kept frames", 32'(rxq.size()), 32'd20);
            for (int f = 0; f < 4; f++)
                chk("R10 order", rxq[f*5], hdr(fc0 + f));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule